// File: doc/BRIEF.md
# Bounce-Supervised Line Debouncer

This block conditions one binary field line that is read at a slow, regular pace. A sample strobe from outside marks each reading of the raw bit. The block reports the line as one of three statuses: ACTIVE, PASSIVE or INVALID. A new level is accepted only after the raw bit has stayed the same for a settle window of consecutive strobes. A short glitch therefore never reaches the status.

A second timer runs alongside the settle logic. It starts on the first edge after a settled period. If the line does not settle within the bounce window, the status is forced to INVALID. The line stays INVALID until it settles again. A one-cycle change flag marks every update of the status, so a consumer can react to events without comparing values itself. Both windows are counted in strobes and set by parameters.

Top module: `line_debounce`

## Requirements
- R1: While rst_n is low, line_state is PASSIVE and state_chg is low. The input history also restarts at 0, so a strobe that samples raw_in=1 first after reset counts as an edge.
- R2: raw_in is examined only in cycles where smp_stb is high. Between strobes, line_state holds and raw_in has no effect on the block.
- R3: A strobe is unchanged when its sample equals the sample of the previous strobe. Once SETTLE_SAMPLES unchanged strobes have followed the last edge, a stabilised event occurs. At that event line_state takes the sampled level: ACTIVE for 1, PASSIVE for 0.
- R4: Every edge restarts the settle count. A pulse that ends before the settle window is complete therefore leaves line_state unchanged once the line settles back to its old level.
- R5: The bounce count starts at 1 on the strobe that carries the first edge after a stabilised event. It then advances on every strobe until the next stabilised event. If strobe number BOUNCE_SAMPLES+1 arrives with no stabilised event, line_state becomes INVALID on that strobe.
- R6: When a stabilised event and the bounce timeout fall on the same strobe, the stabilised event wins and line_state takes the sampled level.
- R7: Once line_state is INVALID, it stays INVALID through further edges and through partial settle windows. It leaves INVALID only at a stabilised event, and then takes the sampled level.
- R8: line_state updates at the clock edge that samples the strobe. state_chg is high for exactly the cycle after each change of line_state, and is low otherwise.
- R9: line_state encodes PASSIVE as 2'b00, ACTIVE as 2'b01 and INVALID as 2'b10. The value 2'b11 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_stb | input | 1 | One-cycle sample strobe |
| raw_in | input | 1 | Raw line level |
| line_state | output | 2 | Filtered three-valued status |
| state_chg | output | 1 | Pulse marking a status update |

## Verification
The bench uses the default windows: a settle window of 3 strobes and a bounce window of 5. With these values a clean transition, a glitch of one or two strobes, and a timeout each fit in a handful of strobes. The small gap between the two windows also lets a sequence make the stabilised event and the timeout fall on the very same strobe, so the priority rule is tested directly. Bouncing that starts while the status is INVALID, and a reset taken from INVALID, are driven as directed sequences.

// File: rtl/line_debounce.sv
module line_debounce #(
  parameter int SETTLE_SAMPLES = 3,
  parameter int BOUNCE_SAMPLES = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       smp_stb,
  input  logic       raw_in,
  output logic [1:0] line_state,
  output logic       state_chg
);
  localparam int SW = $clog2(SETTLE_SAMPLES + 1);
  localparam int BW = $clog2(BOUNCE_SAMPLES + 2);
  localparam logic [SW-1:0] SETTLE_TOP  = SW'(SETTLE_SAMPLES);
  localparam logic [SW-1:0] SETTLE_LAST = SW'(SETTLE_SAMPLES - 1);
  localparam logic [BW-1:0] BOUNCE_OVER = BW'(BOUNCE_SAMPLES + 1);
  localparam logic [1:0] ST_PASSIVE = 2'b00;
  localparam logic [1:0] ST_ACTIVE  = 2'b01;
  localparam logic [1:0] ST_INVALID = 2'b10;

  logic          prev_q, bouncing_q, bouncing_d;
  logic [SW-1:0] settle_q, settle_d;
  logic [BW-1:0] bounce_q, bounce_d;
  logic [1:0]    state_d;

  wire edge_w    = raw_in ^ prev_q;
  wire settled_w = !edge_w && (settle_q == SETTLE_LAST);

  always_comb begin
    if (edge_w)                     settle_d = '0;
    else if (settle_q == SETTLE_TOP) settle_d = settle_q;
    else                            settle_d = settle_q + 1'b1;

    if (settled_w) begin
      bouncing_d = 1'b0;
      bounce_d   = '0;
    end else if (bouncing_q) begin
      bouncing_d = 1'b1;
      bounce_d   = (bounce_q == BOUNCE_OVER) ? bounce_q : bounce_q + 1'b1;
    end else if (edge_w) begin
      bouncing_d = 1'b1;
      bounce_d   = BW'(1);
    end else begin
      bouncing_d = 1'b0;
      bounce_d   = '0;
    end

    state_d = line_state;
    if (settled_w)                               state_d = raw_in ? ST_ACTIVE : ST_PASSIVE;
    else if (bouncing_d && bounce_d == BOUNCE_OVER) state_d = ST_INVALID;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q     <= 1'b0;
      settle_q   <= '0;
      bounce_q   <= '0;
      bouncing_q <= 1'b0;
      line_state <= ST_PASSIVE;
      state_chg  <= 1'b0;
    end else begin
      state_chg <= smp_stb && (state_d != line_state);
      if (smp_stb) begin
        prev_q     <= raw_in;
        settle_q   <= settle_d;
        bounce_q   <= bounce_d;
        bouncing_q <= bouncing_d;
        line_state <= state_d;
      end
    end
  end
endmodule

// File: rtl/line_debounce_chk.sv
module line_debounce_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       smp_stb,
  input logic       raw_in,
  input logic [1:0] line_state,
  input logic       state_chg
);
  assert_reset_passive_R1: assert property (@(posedge clk)
    !rst_n |=> (line_state == 2'b00 && !state_chg));

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_stb |=> $stable(line_state));

  assert_exit_invalid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(line_state) == 2'b10 && line_state != 2'b10)
      |-> line_state == ($past(raw_in) ? 2'b01 : 2'b00));

  assert_chg_only_on_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
    state_chg |-> line_state != $past(line_state));

  assert_change_flagged_R8: assert property (@(posedge clk) disable iff (!rst_n)
    line_state != $past(line_state) |-> state_chg);

  assert_legal_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
    line_state != 2'b11);
endmodule

bind line_debounce line_debounce_chk u_chk (
  .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .raw_in(raw_in),
  .line_state(line_state), .state_chg(state_chg)
);

// File: tb/line_debounce_bench.sv
module line_debounce_bench;
  logic clk = 1'b0, rst_n = 1'b0, smp_stb = 1'b0, raw_in = 1'b0;
  logic [1:0] line_state;
  logic state_chg;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  line_debounce u_line_debounce (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .raw_in(raw_in),
    .line_state(line_state), .state_chg(state_chg)
  );

  // {raw, expected state_chg, expected line_state}
  localparam logic [3:0] VEC [35] = '{
    4'b0000, 4'b0000, 4'b0000, 4'b0000,                     // R1 history zero
    4'b1000, 4'b1000, 4'b1000, 4'b1101,                     // R3 clean rise
    4'b0001, 4'b1001, 4'b1001, 4'b1001, 4'b1001,            // R4 glitch
    4'b0001, 4'b1001, 4'b0001, 4'b1001, 4'b0001, 4'b1110,   // R5 timeout
    4'b0010, 4'b0010, 4'b0010, 4'b0100,                     // R7 recovery
    4'b1000, 4'b1000, 4'b0000, 4'b0000, 4'b0000, 4'b0000,   // R6 tie, same level
    4'b1000, 4'b0000, 4'b1000, 4'b1000, 4'b1000, 4'b1101    // R6 tie, new level
  };

  function automatic string tag_of(int i);
    if (i < 4)  return "R1";
    if (i < 8)  return "R3";
    if (i < 13) return "R4";
    if (i < 19) return "R5";
    if (i < 23) return "R7";
    return "R6";
  endfunction

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {chg,state} got %b expected %b", req, act, exp);
    end
  endtask

  task automatic strobe(input logic v);
    @(negedge clk);
    raw_in  = v;
    smp_stb = 1'b1;
    @(negedge clk);
    smp_stb = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", {state_chg, line_state}, 3'b000);
    rst_n = 1'b1;

    for (int i = 0; i < 35; i++) begin
      strobe(VEC[i][3]);
      chk(tag_of(i), {state_chg, line_state}, VEC[i][2:0]);
      if (VEC[i][2]) begin
        @(negedge clk);
        chk("R8", {state_chg, line_state}, {1'b0, VEC[i][1:0]});
      end
    end

    // R2: level held low with no strobes must not be taken
    raw_in = 1'b0;
    repeat (10) @(negedge clk);
    chk("R2", {state_chg, line_state}, 3'b001);
    strobe(1'b1);
    chk("R2", {state_chg, line_state}, 3'b001);

    // R7: bounce to INVALID, partial settles keep it there
    for (int k = 0; k < 5; k++) strobe(k % 2 == 0 ? 1'b0 : 1'b1);
    chk("R5", {state_chg, line_state}, 3'b001);
    strobe(1'b1);
    chk("R5", {state_chg, line_state}, 3'b110);
    strobe(1'b1);
    strobe(1'b1);
    chk("R7", {state_chg, line_state}, 3'b010);
    strobe(1'b0);
    strobe(1'b0);
    strobe(1'b0);
    chk("R7", {state_chg, line_state}, 3'b010);
    strobe(1'b0);
    chk("R7", {state_chg, line_state}, 3'b100);

    // R1: reset from INVALID, then history restarts at 0
    for (int k = 0; k < 6; k++) strobe(k % 2 == 0 ? 1'b1 : 1'b0);
    chk("R5", {state_chg, line_state}, 3'b110);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", {state_chg, line_state}, 3'b000);
    rst_n = 1'b1;
    strobe(1'b1);
    strobe(1'b1);
    strobe(1'b1);
    chk("R1", {state_chg, line_state}, 3'b000);
    strobe(1'b1);
    chk("R3", {state_chg, line_state}, 3'b101);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule